// File: doc/BRIEF.md
# Sleep and power-button override controller

This block holds an 8-bit power management control byte and the sequencing behind it. Software writes the byte through a plain byte-wide register port. One field selects a sleep type. A write-only trigger bit requests sleep entry. A further bit enables a long-press override of the power button. The block drives an active-high power-enable output, which firmware and board logic treat as released when it is low. It also drives a one-cycle SMI request and three sticky status flags.

Everything runs on one system clock. The 32 kHz real-time clock arrives as a one-cycle `rtc_tick` strobe, and the block uses it for two things. Sleep entry with sleep type 000 removes power at the second tick edge after the write, which gives a delay of one to two RTC periods. A button held long enough with the override enabled also forces power off. The button input and the sleep-control configuration bit are already debounced and synchronous to `clk`. Once power is removed, it stays removed until the next reset.

Top module: `sleep_override_ctl`

## Requirements
- R1: After reset, `rdata` is 8'h00, `pwr_on` is 1, and `smi_req`, `pwrbtn_sts`, `pwrbtnor_sts` and `slp_smi_sts` are all 0.
- R2: A write stores bit 1 as the override enable and bits 4:2 as the sleep type. `rdata` returns these fields at the same positions, and bits 0, 5, 6 and 7 of `rdata` always read 0.
- R3: A write with bit 5 set makes `slp_smi_sts` 1 from the next cycle, whatever the value of `sleep_ctl`. A write with bit 5 clear changes neither `slp_smi_sts` nor `pwr_on`.
- R4: A write with bit 5 set while `sleep_ctl` is 1 raises `smi_req` for exactly the cycle after the write, and `pwr_on` stays 1.
- R5: A write with bit 5 set, `sleep_ctl` 0 and bits 4:2 equal to 000 keeps `pwr_on` at 1 through the first `rtc_tick` edge after the write. It clears `pwr_on` at the second such edge, and `pwr_on` then stays 0 until reset.
- R6: A write with bit 5 set, `sleep_ctl` 0 and a non-zero value in bits 4:2 leaves `pwr_on` at 1 and raises no `smi_req`.
- R7: A rising edge of `btn` sets `pwrbtn_sts` in the following cycle.
- R8: With the override enabled and `btn` held, `pwr_on` stays 1 for HOLD_TICKS ticks and clears at the next one. That same edge clears `pwrbtn_sts` and sets `pwrbtnor_sts`.
- R9: Releasing `btn` for at least one cycle before the override fires restarts the tick count from zero.
- R10: With the override disabled, holding `btn` for any number of ticks leaves `pwr_on` at 1 and `pwrbtnor_sts` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low battery power-on reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Register read data |
| sleep_ctl | input | 1 | Configuration bit: 1 sends sleep requests to SMI instead of sleeping |
| rtc_tick | input | 1 | One-cycle strobe per 32 kHz RTC period |
| btn | input | 1 | Debounced power button, 1 = pressed |
| pwr_on | output | 1 | Power enable, 1 = powered, 0 = released |
| smi_req | output | 1 | One-cycle SMI request |
| pwrbtn_sts | output | 1 | Power button pressed flag |
| pwrbtnor_sts | output | 1 | Override event flag |
| slp_smi_sts | output | 1 | Sleep-enable written flag |

## Verification
`rdata` is combinational and is sampled in the cycle after a write. `smi_req` and `slp_smi_sts` are registered, so the bench samples them at the falling edge that follows the write edge. Power removal is counted in `rtc_tick` edges, not clock cycles. The bench drives each tick as a single strobe and checks `pwr_on` after the first tick edge (still on) and after the second (off). The override is checked the same way: once after HOLD_TICKS held ticks (still on) and once after one more (off, flags swapped). A short HOLD_TICKS keeps the bench fast.

// File: rtl/sleep_override_ctl.sv
module sleep_override_ctl #(
  parameter int HOLD_TICKS = 131072
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       sleep_ctl,
  input  logic       rtc_tick,
  input  logic       btn,
  output logic       pwr_on,
  output logic       smi_req,
  output logic       pwrbtn_sts,
  output logic       pwrbtnor_sts,
  output logic       slp_smi_sts
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_TICKS);

  logic          or_en;
  logic [2:0]    slp_type;
  logic          pend, armed, btn_q;
  logic [CW-1:0] hold_cnt;

  wire slp_wr    = wr_en & wdata[5];
  wire go_sleep  = slp_wr & ~sleep_ctl & (wdata[4:2] == 3'b000);
  wire counting  = btn & or_en & pwr_on;
  wire hold_done = rtc_tick & counting & (hold_cnt == HOLD_MAX);

  assign rdata = {3'b000, slp_type, or_en, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      or_en        <= 1'b0;
      slp_type     <= 3'b000;
      pend         <= 1'b0;
      armed        <= 1'b0;
      btn_q        <= 1'b0;
      hold_cnt     <= '0;
      pwr_on       <= 1'b1;
      smi_req      <= 1'b0;
      pwrbtn_sts   <= 1'b0;
      pwrbtnor_sts <= 1'b0;
      slp_smi_sts  <= 1'b0;
    end else begin
      if (wr_en) begin
        or_en    <= wdata[1];
        slp_type <= wdata[4:2];
      end
      smi_req <= slp_wr & sleep_ctl;
      if (slp_wr) slp_smi_sts <= 1'b1;

      if (go_sleep) pend <= 1'b1;
      else if (rtc_tick && pend) begin
        pend  <= 1'b0;
        armed <= 1'b1;
      end
      if (rtc_tick && armed) pwr_on <= 1'b0;

      btn_q <= btn;
      if (!counting) hold_cnt <= '0;
      else if (rtc_tick && hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;

      if (hold_done) begin
        pwr_on       <= 1'b0;
        pwrbtn_sts   <= 1'b0;
        pwrbtnor_sts <= 1'b1;
      end else if (btn && !btn_q) begin
        pwrbtn_sts <= 1'b1;
      end
    end
  end
endmodule

module sleep_override_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       sleep_ctl,
  input logic       rtc_tick,
  input logic [7:0] rdata,
  input logic       pwr_on,
  input logic       smi_req,
  input logic       pwrbtn_sts,
  input logic       pwrbtnor_sts,
  input logic       slp_smi_sts
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 8'hE1) == 8'h00);
  // R4
  smi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(wr_en && wdata[5] && sleep_ctl));
  // R3
  slp_sts_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slp_smi_sts) |-> $past(wr_en && wdata[5]));
  // R5
  pwr_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on) |-> $past(rtc_tick));
  // R5
  pwr_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !pwr_on);
  // R8
  override_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrbtnor_sts) |-> (!pwr_on && !pwrbtn_sts));
endmodule

bind sleep_override_ctl sleep_override_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .sleep_ctl(sleep_ctl), .rtc_tick(rtc_tick), .rdata(rdata),
  .pwr_on(pwr_on), .smi_req(smi_req), .pwrbtn_sts(pwrbtn_sts),
  .pwrbtnor_sts(pwrbtnor_sts), .slp_smi_sts(slp_smi_sts)
);

// File: tb/sim_sleep_override_ctl.sv
module sim_sleep_override_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sleep_ctl = 1'b0;
  logic       rtc_tick = 1'b0, btn = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pwr_on, smi_req, pwrbtn_sts, pwrbtnor_sts, slp_smi_sts;
  int         nvec = 0, nbad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_override_ctl #(.HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .sleep_ctl(sleep_ctl), .rtc_tick(rtc_tick), .btn(btn), .pwr_on(pwr_on),
    .smi_req(smi_req), .pwrbtn_sts(pwrbtn_sts), .pwrbtnor_sts(pwrbtnor_sts),
    .slp_smi_sts(slp_smi_sts));

  // {sleep_ctl, wdata, expected rdata, expected smi_req, expected slp_smi_sts}
  localparam logic [18:0] VEC [9] = '{
    {1'b0, 8'h02, 8'h02, 1'b0, 1'b0},
    {1'b0, 8'h04, 8'h04, 1'b0, 1'b0},
    {1'b0, 8'h24, 8'h04, 1'b0, 1'b1},
    {1'b1, 8'h20, 8'h00, 1'b1, 1'b1},
    {1'b0, 8'hC1, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h1C, 8'h1C, 1'b0, 1'b1},
    {1'b1, 8'hFF, 8'h1E, 1'b1, 1'b1},
    {1'b0, 8'h3E, 8'h1E, 1'b0, 1'b1},
    {1'b0, 8'h08, 8'h08, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wdata = 8'h00; sleep_ctl = 1'b0;
    rtc_tick = 1'b0; btn = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic ctl, input logic [7:0] d);
    sleep_ctl = ctl; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    rtc_tick = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pwr_on", {7'b0, pwr_on}, 8'h01);
    chk("R1 smi_req", {7'b0, smi_req}, 8'h00);
    chk("R1 flags", {5'b0, pwrbtn_sts, pwrbtnor_sts, slp_smi_sts}, 8'h00);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][18], VEC[i][17:10]);
      chk("R2 rdata", rdata, VEC[i][9:2]);
      chk("R4 smi_req", {7'b0, smi_req}, {7'b0, VEC[i][1]});
      chk("R3 slp_smi_sts", {7'b0, slp_smi_sts}, {7'b0, VEC[i][0]});
      @(negedge clk);
      chk("R4 smi_req one cycle", {7'b0, smi_req}, 8'h00);
      repeat (3) tick();
      chk("R6 pwr_on kept", {7'b0, pwr_on}, 8'h01);
    end

    // R5 sleep type 000 entry
    do_reset();
    wr(1'b0, 8'h20);
    chk("R5 no smi", {7'b0, smi_req}, 8'h00);
    repeat (5) @(negedge clk);
    chk("R5 before tick", {7'b0, pwr_on}, 8'h01);
    tick();
    chk("R5 after first tick", {7'b0, pwr_on}, 8'h01);
    tick();
    chk("R5 after second tick", {7'b0, pwr_on}, 8'h00);
    repeat (3) tick();
    chk("R5 stays off", {7'b0, pwr_on}, 8'h00);

    // R7 and R8 override
    do_reset();
    wr(1'b0, 8'h02);
    btn = 1'b1;
    @(negedge clk);
    chk("R7 pwrbtn_sts", {7'b0, pwrbtn_sts}, 8'h01);
    repeat (HOLD) tick();
    chk("R8 before threshold", {7'b0, pwr_on}, 8'h01);
    tick();
    chk("R8 pwr_on off", {7'b0, pwr_on}, 8'h00);
    chk("R8 flags swap", {6'b0, pwrbtn_sts, pwrbtnor_sts}, 8'h01);
    btn = 1'b0;

    // R9 release restarts count
    do_reset();
    wr(1'b0, 8'h02);
    btn = 1'b1;
    repeat (HOLD) tick();
    btn = 1'b0;
    @(negedge clk);
    btn = 1'b1;
    repeat (HOLD) tick();
    chk("R9 count restarted", {7'b0, pwr_on}, 8'h01);
    chk("R9 no override yet", {7'b0, pwrbtnor_sts}, 8'h00);
    tick();
    chk("R9 override after full hold", {7'b0, pwr_on}, 8'h00);
    btn = 1'b0;

    // R10 override disabled
    do_reset();
    btn = 1'b1;
    repeat (HOLD + 3) tick();
    chk("R10 pwr_on kept", {7'b0, pwr_on}, 8'h01);
    chk("R10 no override flag", {7'b0, pwrbtnor_sts}, 8'h00);
    chk("R7 press flag", {7'b0, pwrbtn_sts}, 8'h01);
    btn = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule